// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It is meant for the fetch stage of a 32-bit in-order pipeline. It holds three tables of 2-bit saturating counters:

- a **global table**, indexed by a shift register of recent branch outcomes;
- a **local table**, indexed by instruction-address bits joined to a short outcome history kept for each address slot;
- a **selector table**, indexed by address bits, whose counter picks which of the two component guesses is used.

Fetch drives a PC and reads the direction in the same cycle. Fetch also receives the table indices that were used and the guess of each component. These travel down the pipe with the branch. When decode resolves the branch, it returns the PC, the real outcome and that bundle. Training then writes the entries that made the guess, even if the histories have moved on since.

The address slot is PC[IDX_W+1:2]. The production setting is IDX_W=10, GH_W=10 and LH_W=3, which gives PC[11:2], ten global outcomes, three local outcomes and an 8192-entry local table. The parameter defaults are smaller, so that elaboration stays light.

Top module: `tourney_dir_predictor`

## Requirements
- R1: After reset, every direction counter holds 1 (weakly not taken) and every selector counter holds 1 (weakly prefer local). The global history and all local histories are zero. So every PC predicts not taken, with predUseGlobal=0, predGlobalIdx=0 and predLocalIdx={PC[IDX_W+1:2], zeros}.
- R2: The selector entry is chosen by PC[IDX_W+1:2]. When its counter is 2 or 3, predUseGlobal is 1 and predTaken follows the global guess; otherwise predTaken follows the local guess.
- R3: All counters are 2-bit and saturating. A taken outcome adds one and stops at 3; a not-taken outcome subtracts one and stops at 0. Bit 1 of a counter is its guess (1 = taken).
- R4: predGlobalIdx equals the global history register. Each update shifts the resolved outcome into bit 0, and the oldest bit falls out of the top.
- R5: The selector entry at the update PC moves one step toward global when only the global guess was right. It moves one step toward local when only the local guess was right. It is unchanged when both guesses were right or both were wrong.
- R6: predLocalIdx is {PC[IDX_W+1:2], h}, where h is the local history of that address slot. Each update shifts the outcome into bit 0 of the history of the update PC's slot.
- R7: On update, the global and local counters trained are the ones at updGlobalIdx and updLocalIdx as supplied, not at the indices the current histories would give. Both are always trained with the real outcome.
- R8: The prediction outputs are combinational in fetchPc and the current state. An update takes effect in the predictions from the cycle after the clock edge that samples it.
- R9: While updValid is 0, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address of the instruction being fetched |
| predTaken | output | 1 | Chosen direction |
| predUseGlobal | output | 1 | Selector picked the global component |
| predGlobalTaken | output | 1 | Global component guess |
| predLocalTaken | output | 1 | Local component guess |
| predGlobalIdx | output | GH_W | Global table index used |
| predLocalIdx | output | IDX_W+LH_W | Local table index used |
| updValid | input | 1 | A resolved branch is being returned |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Real outcome |
| updGlobalIdx | input | GH_W | Global index captured at fetch |
| updLocalIdx | input | IDX_W+LH_W | Local index captured at fetch |
| updGlobalTaken | input | 1 | Global guess captured at fetch |
| updLocalTaken | input | 1 | Local guess captured at fetch |

## Verification
The embedded properties assume the following about the inputs:

- updValid and the other update inputs are known, two-valued levels that stay steady through each sampling edge.
- The returned indices are within the table depths, which holds by width.

The bench runs a small configuration with sixteen address slots. It changes update inputs only on the falling edge, and it holds updValid low during every prediction sweep. This keeps state steady while all slots are read.

Some updates carry stale fetch metadata on purpose. Some idle cycles carry random values on the ignored update inputs.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef struct packed {
    logic wrChooser;
    logic chooserUp;
    logic wrDir;
    logic dirUp;
    logic shiftHist;
  } trainStrobes_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tourney_ctr_table.sv
module tourney_ctr_table #(
  parameter int IDX_W = 8,
  parameter logic [1:0] RESET_VAL = 2'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [1:0]       rdVal,
  input  logic             wrEn,
  input  logic             wrUp,
  input  logic [IDX_W-1:0] wrIdx
);
  import tourney_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] mem [DEPTH];

  assign rdVal = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RESET_VAL;
    end else if (wrEn) begin
      mem[wrIdx] <= satStep(mem[wrIdx], wrUp);
    end
  end

  // R3: counting up below the ceiling adds exactly one
  assert_ctr_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrUp && mem[wrIdx] != 2'd3) |=> mem[$past(wrIdx)] == 2'($past(mem[wrIdx]) + 2'd1));

  // R3: counting down at zero stays at zero
  assert_ctr_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrUp && mem[wrIdx] == 2'd0) |=> mem[$past(wrIdx)] == 2'd0);

  // R3: counting up at three stays at three
  assert_ctr_ceiling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrUp && mem[wrIdx] == 2'd3) |=> mem[$past(wrIdx)] == 2'd3);

endmodule

// File: rtl/tourney_ctrl.sv
module tourney_ctrl (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        updValid,
  input  logic                        updTaken,
  input  logic                        updGlobalTaken,
  input  logic                        updLocalTaken,
  output tourney_pkg::trainStrobes_t  strobes
);
  logic globalRight;
  logic localRight;

  assign globalRight = (updGlobalTaken == updTaken);
  assign localRight  = (updLocalTaken == updTaken);

  always_comb begin
    strobes           = '0;
    strobes.wrDir     = updValid;
    strobes.dirUp     = updTaken;
    strobes.shiftHist = updValid;
    strobes.wrChooser = updValid && (globalRight != localRight);
    strobes.chooserUp = globalRight;
  end

  // R5: when both components agree, the selector is left alone
  assert_chooser_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updGlobalTaken == updLocalTaken) |-> !strobes.wrChooser);

  // R9: no training strobe without a valid update
  assert_idle_no_train_R9: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strobes.wrDir || strobes.wrChooser || strobes.shiftHist));

endmodule

// File: rtl/tourney_datapath.sv
module tourney_datapath #(
  parameter int IDX_W = 8,
  parameter int GH_W  = 8,
  parameter int LH_W  = 3,
  localparam int LOC_W = IDX_W + LH_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [31:0]                fetchPc,
  output logic                       predTaken,
  output logic                       predUseGlobal,
  output logic                       predGlobalTaken,
  output logic                       predLocalTaken,
  output logic [GH_W-1:0]            predGlobalIdx,
  output logic [LOC_W-1:0]           predLocalIdx,
  input  logic [31:0]                updPc,
  input  logic                       updTaken,
  input  logic [GH_W-1:0]            updGlobalIdx,
  input  logic [LOC_W-1:0]           updLocalIdx,
  input  tourney_pkg::trainStrobes_t strobes
);
  localparam int SLOTS = 1 << IDX_W;

  logic [GH_W-1:0]  ghr;
  logic [LH_W-1:0]  lhist [SLOTS];
  logic [IDX_W-1:0] fetchIdx;
  logic [IDX_W-1:0] updIdx;
  logic [LOC_W-1:0] localIdx;
  logic [1:0]       chooserVal;
  logic [1:0]       globalVal;
  logic [1:0]       localVal;
  logic             unusedPcBits;

  assign fetchIdx     = fetchPc[IDX_W+1:2];
  assign updIdx       = updPc[IDX_W+1:2];
  assign unusedPcBits = ^{fetchPc[31:IDX_W+2], fetchPc[1:0], updPc[31:IDX_W+2], updPc[1:0]};
  assign localIdx     = {fetchIdx, lhist[fetchIdx]};

  tourney_ctr_table #(.IDX_W(IDX_W), .RESET_VAL(2'd1)) chooserTab (
    .clk(clk), .rstN(rstN), .rdIdx(fetchIdx), .rdVal(chooserVal),
    .wrEn(strobes.wrChooser), .wrUp(strobes.chooserUp), .wrIdx(updIdx));

  tourney_ctr_table #(.IDX_W(GH_W), .RESET_VAL(2'd1)) globalTab (
    .clk(clk), .rstN(rstN), .rdIdx(ghr), .rdVal(globalVal),
    .wrEn(strobes.wrDir), .wrUp(strobes.dirUp), .wrIdx(updGlobalIdx));

  tourney_ctr_table #(.IDX_W(LOC_W), .RESET_VAL(2'd1)) localTab (
    .clk(clk), .rstN(rstN), .rdIdx(localIdx), .rdVal(localVal),
    .wrEn(strobes.wrDir), .wrUp(strobes.dirUp), .wrIdx(updLocalIdx));

  assign predUseGlobal   = chooserVal[1];
  assign predGlobalTaken = globalVal[1];
  assign predLocalTaken  = localVal[1];
  assign predTaken       = predUseGlobal ? predGlobalTaken : predLocalTaken;
  assign predGlobalIdx   = ghr;
  assign predLocalIdx    = localIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ghr <= '0;
      for (int i = 0; i < SLOTS; i++) lhist[i] <= '0;
    end else if (strobes.shiftHist) begin
      ghr           <= GH_W'({ghr, updTaken});
      lhist[updIdx] <= LH_W'({lhist[updIdx], updTaken});
    end
  end

  // R4: the newest outcome lands in bit 0 of the global history
  assert_ghr_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftHist |=> ghr[0] == $past(updTaken));

  // R9: the global history holds when nothing is trained
  assert_ghr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftHist |=> $stable(ghr));

  // R6: the newest outcome lands in bit 0 of the slot's local history
  assert_lhist_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftHist |=> lhist[$past(updIdx)][0] == $past(updTaken));

endmodule

// File: rtl/tourney_dir_predictor.sv
module tourney_dir_predictor #(
  parameter int IDX_W = 8,
  parameter int GH_W  = 8,
  parameter int LH_W  = 3,
  localparam int LOC_W = IDX_W + LH_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      fetchPc,
  output logic             predTaken,
  output logic             predUseGlobal,
  output logic             predGlobalTaken,
  output logic             predLocalTaken,
  output logic [GH_W-1:0]  predGlobalIdx,
  output logic [LOC_W-1:0] predLocalIdx,
  input  logic             updValid,
  input  logic [31:0]      updPc,
  input  logic             updTaken,
  input  logic [GH_W-1:0]  updGlobalIdx,
  input  logic [LOC_W-1:0] updLocalIdx,
  input  logic             updGlobalTaken,
  input  logic             updLocalTaken
);
  tourney_pkg::trainStrobes_t strobes;

  tourney_ctrl ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
    .updGlobalTaken(updGlobalTaken), .updLocalTaken(updLocalTaken),
    .strobes(strobes));

  tourney_datapath #(.IDX_W(IDX_W), .GH_W(GH_W), .LH_W(LH_W)) dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predUseGlobal(predUseGlobal),
    .predGlobalTaken(predGlobalTaken), .predLocalTaken(predLocalTaken),
    .predGlobalIdx(predGlobalIdx), .predLocalIdx(predLocalIdx),
    .updPc(updPc), .updTaken(updTaken), .updGlobalIdx(updGlobalIdx),
    .updLocalIdx(updLocalIdx), .strobes(strobes));

  // R2: the chosen direction matches the component the selector names
  assert_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    predUseGlobal |-> predTaken == predGlobalTaken);

endmodule

// File: tb/tourney_dir_predictor_test.sv
`timescale 1ns/1ps
module tourney_dir_predictor_test;
  localparam int IW = 4, GW = 4, LW = 2, LOCW = IW + LW;
  localparam int SLOTS = 1 << IW;

  logic clk = 0, rstN = 0;
  logic [31:0] fetchPc = 0, updPc = 0;
  logic predTaken, predUseGlobal, predGlobalTaken, predLocalTaken;
  logic [GW-1:0] predGlobalIdx;
  logic [LOCW-1:0] predLocalIdx;
  logic updValid = 0, updTaken = 0, updGlobalTaken = 0, updLocalTaken = 0;
  logic [GW-1:0] updGlobalIdx = 0;
  logic [LOCW-1:0] updLocalIdx = 0;

  int checks = 0, fails = 0;
  int mCh[SLOTS], mG[1<<GW], mL[1<<LOCW], mLh[SLOTS], mGhr;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  tourney_dir_predictor #(.IDX_W(IW), .GH_W(GW), .LH_W(LW)) uut (.*);

  function automatic int sat(int v, bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Read every slot while updValid is low and compare with the model
  task automatic sweep(string tag);
    for (int i = 0; i < SLOTS; i++) begin
      int useG, gT, lIdx, lT;
      step();
      fetchPc = {lfsr, 10'(lfsr), IW'(i), 2'(lfsr)};
      #0.2;
      useG = (mCh[i] >= 2);
      gT   = (mG[mGhr] >= 2);
      lIdx = i * (1 << LW) + mLh[i];
      lT   = (mL[lIdx] >= 2);
      chk({tag, " R2 R5 selector"}, predUseGlobal, useG);
      chk({tag, " R4 globalIdx"}, predGlobalIdx, mGhr);
      chk({tag, " R6 localIdx"}, predLocalIdx, lIdx);
      chk({tag, " R3 R8 taken"}, predTaken, useG ? gT : lT);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int sgIdx, slIdx, sgT, slT;
    for (int i = 0; i < SLOTS; i++) begin mCh[i] = 1; mLh[i] = 0; end
    for (int i = 0; i < (1 << GW); i++) mG[i] = 1;
    for (int i = 0; i < (1 << LOCW); i++) mL[i] = 1;
    mGhr = 0;
    sgIdx = 0; slIdx = 0; sgT = 0; slT = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    sweep("R1");

    for (int k = 0; k < 400; k++) begin
      int idx, gIdx, lIdx, gT, lT, t;
      bit stale;
      step();
      idx = int'(lfsr[7:4]);
      t = (idx < 8) ? int'(lfsr[3:0] != 0) : int'(lfsr[0]);
      if (k > 200 && k < 260) t = 1;           // drive counters to the ceiling
      if (k >= 260 && k < 320) t = 0;          // and back to the floor
      @(negedge clk);
      fetchPc = {20'h0, 6'(idx << 2), 6'h0} | 32'(idx << 2);
      #0.2;
      gIdx = mGhr; lIdx = idx * (1 << LW) + mLh[idx];
      gT = (mG[gIdx] >= 2); lT = (mL[lIdx] >= 2);
      chk("R8 fetch globalIdx", predGlobalIdx, gIdx);
      chk("R8 fetch localIdx", predLocalIdx, lIdx);
      stale = (k % 4 == 3);
      if (stale) begin gIdx = sgIdx; lIdx = slIdx; gT = sgT; lT = slT; end
      else begin sgIdx = gIdx; slIdx = lIdx; sgT = gT; slT = lT; end
      updPc = 32'(idx << 2); updTaken = t[0];
      updGlobalIdx = GW'(gIdx); updLocalIdx = LOCW'(lIdx);
      updGlobalTaken = gT[0]; updLocalTaken = lT[0];
      updValid = 1;
      @(negedge clk);
      updValid = 0;
      // model of the requirements: R5, R7, R3, R4, R6
      if ((gT == t) != (lT == t)) mCh[idx] = sat(mCh[idx], gT == t);
      mG[gIdx] = sat(mG[gIdx], t[0]);
      mL[lIdx] = sat(mL[lIdx], t[0]);
      mGhr = ((mGhr << 1) | t) & ((1 << GW) - 1);
      mLh[idx] = ((mLh[idx] << 1) | t) & ((1 << LW) - 1);
      if (stale) sweep("R7"); else sweep("R8");
      if (k % 16 == 5) begin
        // R9: garbage on update inputs with updValid low
        repeat (3) begin
          step();
          updPc = {lfsr, lfsr}; updTaken = lfsr[1];
          updGlobalIdx = GW'(lfsr[9:6]); updLocalIdx = LOCW'(lfsr[15:10]);
          updGlobalTaken = lfsr[2]; updLocalTaken = lfsr[3];
          @(negedge clk);
        end
        sweep("R9");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule